// File: doc/BRIEF.md
# Codec power-down interlock controller

This block owns the power-control and ready-status register of a mixed-signal audio codec. Software writes seven power-down request bits over a simple register bus. The block does not pass these bits straight to the subsections. It filters them through dependency rules, then drives one enable line for each subsection: ADC, DAC, analog mixer, voltage reference, serial link, internal clock and headphone driver.

The rules work as follows. The reference powers up first, and the analog subsections and the headphone wait until it reports ready. The reference may only drop once both converters are off. The internal clock may only stop once the converters and the link are off and every power-up in progress has finished. A settle counter per analog subsection stands in for analog settling time and produces the ready flags that software reads back.

In a multi-codec system, an instance strapped as a slave takes its link request from the master. Its clock request is the OR of the master's request and its own.

Top module: `codec_pwr_ctl`

## Requirements
- R1: After `rst_n` rises, the block stays in its reset state for two more rising clock edges. In the reset state the stored requests are all zero and all settle counters are cleared. The enable outputs are 7'h38 (only reference, link and clock enabled) and `bus_rdata` reads 16'h0000.
- R2: A write with `bus_we` high and `bus_addr` equal to `REG_IDX` (default 7'h26) stores `bus_wdata[14:8]` as the request bits. Bit 8 is ADC, 9 DAC, 10 mixer, 11 reference, 12 link, 13 clock and 14 headphone, and 1 means "power down". Writes to any other address change nothing. `bus_rdata` returns the requests in bits 14:8 and the ready flags in bits 3:0, with zero in every other bit. The value of `bus_wdata` in bits 3:0 is ignored.
- R3: The ready flag order in `bus_rdata[3:0]` is bit 0 ADC, bit 1 DAC, bit 2 mixer, bit 3 reference. A flag reads 1 once its subsection has stayed enabled for its settle count of rising edges. It returns to 0 in the same cycle that the subsection's enable falls.
- R4: `sub_en` bits 0 (ADC), 1 (DAC), 2 (mixer) and 6 (headphone) are 0 while the reference ready flag is 0. While the reference flag is 1, each of these bits is the inverse of its request bit.
- R5: `sub_en[3]` (reference) is 0 only when the ADC, DAC and reference request bits are all 1.
- R6: `sub_en[5]` (clock) can be 0 only when the clock request is active, the ADC and DAC requests are set, and the effective link request is set.
- R7: While any enabled ADC, DAC, mixer or reference is still counting toward ready, `sub_en[5]` stays 1.
- R8: `sub_en[4]` (link) is the inverse of the effective link request. With `slave_mode` high this request is `mst_link_off` and the local link request bit is ignored. With `slave_mode` low it is the local request bit.
- R9: With `slave_mode` high, the effective clock request is the local clock request bit ORed with `mst_clk_off`. With `slave_mode` low it is the local bit alone.
- R10: Writing all seven request bits as 1 (standby) drives every `sub_en` bit to 0 and every ready flag to 0 from the cycle after the write.
- R11: The headphone request bit affects only `sub_en[6]`, subject to the reference gating of R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register index |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data: requests and ready flags |
| slave_mode | input | 1 | High when this instance follows a master |
| mst_link_off | input | 1 | Master's link power-down request |
| mst_clk_off | input | 1 | Master's clock power-down request |
| sub_en | output | 7 | Effective enables: ADC, DAC, mixer, reference, link, clock, headphone (bit 0 up) |

## Verification
A write lands in the stored requests on the rising edge where `bus_we` is sampled. Readback and every enable that depends only on requests therefore change one edge after the write. A ready flag rises after its settle count of further edges, and the gated analog enables follow the reference flag in the same cycle. The master-side inputs act on `sub_en` combinationally, with no register in the path.

The bench drives all inputs on falling edges. It keeps a cycle-accurate model that advances on rising edges, and it compares every output at the next falling edge, which is after all of these paths have settled. Directed checks use constants counted out by hand from the settle lengths, for example 9 plus 4 edges before the clock may stop with the mixer coming up.

// File: rtl/cpc_pkg.sv
package cpc_pkg;
  localparam int REG_W   = 16;
  localparam int NSUB    = 7;
  localparam int NRDY    = 4;
  localparam int REQ_LSB = 8;

  localparam int SUB_ADC  = 0;
  localparam int SUB_DAC  = 1;
  localparam int SUB_MIX  = 2;
  localparam int SUB_REF  = 3;
  localparam int SUB_LINK = 4;
  localparam int SUB_CLK  = 5;
  localparam int SUB_HP   = 6;

  typedef logic [NSUB-1:0] sub_vec_t;
  typedef logic [NRDY-1:0] rdy_vec_t;
endpackage

// File: rtl/cpc_rst_sync.sv
module cpc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/cpc_regfile.sv
module cpc_regfile
  import cpc_pkg::*;
#(
  parameter int                ADDR_W  = 7,
  parameter logic [ADDR_W-1:0] REG_IDX = 7'h26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  input  rdy_vec_t          rdy,
  output sub_vec_t          req,
  output logic [REG_W-1:0]  rdata
);
  logic     hit;
  sub_vec_t req_q;
  sub_vec_t req_d;

  always_comb begin
    hit   = we && (addr == REG_IDX);
    req_d = hit ? wdata[REQ_LSB +: NSUB] : req_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   req_q <= '0;
    else if (hit) req_q <= req_d;
  end

  always_comb begin
    rdata                    = '0;
    rdata[REQ_LSB +: NSUB]   = req_q;
    rdata[NRDY-1:0]          = rdy;
  end

  assign req = req_q;

  // R2
  wr_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> rdata[REQ_LSB +: NSUB] == $past(wdata[REQ_LSB +: NSUB]));
endmodule

// File: rtl/cpc_settle.sv
module cpc_settle #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  output logic ready,
  output logic busy
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          done;
  logic          upd;

  always_comb begin
    done = (cnt_q == CW'(LIMIT));
    if (!go)       cnt_d = '0;
    else if (!done) cnt_d = cnt_q + 1'b1;
    else           cnt_d = cnt_q;
    upd = (cnt_d != cnt_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (upd) cnt_q <= cnt_d;
  end

  assign ready = go && done;
  assign busy  = go && !done;

  // R3
  rdy_after_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(go));

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(LIMIT));
endmodule

// File: rtl/cpc_interlock.sv
module cpc_interlock
  import cpc_pkg::*;
(
  input  sub_vec_t   req,
  input  logic       slave_mode,
  input  logic       mst_link_off,
  input  logic       mst_clk_off,
  input  logic       ref_rdy,
  input  logic       settling,
  output logic       ref_en,
  output logic [2:0] ana_en,
  output logic       hp_en,
  output logic       link_en,
  output logic       clk_en
);
  logic conv_off;
  logic link_off;
  logic clk_req;

  always_comb begin
    conv_off = req[SUB_ADC] & req[SUB_DAC];
    ref_en   = !(req[SUB_REF] & conv_off);
    ana_en   = ~req[SUB_MIX:SUB_ADC] & {3{ref_rdy}};
    hp_en    = !req[SUB_HP] & ref_rdy;
    link_off = slave_mode ? mst_link_off : req[SUB_LINK];
    clk_req  = req[SUB_CLK] | (slave_mode & mst_clk_off);
    link_en  = !link_off;
    clk_en   = !(clk_req & conv_off & link_off & !settling);
  end
endmodule

// File: rtl/codec_pwr_ctl.sv
module codec_pwr_ctl
  import cpc_pkg::*;
#(
  parameter int                ADDR_W     = 7,
  parameter logic [ADDR_W-1:0] REG_IDX    = 7'h26,
  parameter int                ADC_SETTLE = 5,
  parameter int                DAC_SETTLE = 7,
  parameter int                MIX_SETTLE = 4,
  parameter int                REF_SETTLE = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  input  logic              slave_mode,
  input  logic              mst_link_off,
  input  logic              mst_clk_off,
  output logic [6:0]        sub_en
);
  localparam int SETTLE_TAB [NRDY] = '{ADC_SETTLE, DAC_SETTLE, MIX_SETTLE, REF_SETTLE};

  logic       rst_i_n;
  sub_vec_t   req;
  rdy_vec_t   rdy_v;
  rdy_vec_t   busy_v;
  rdy_vec_t   go_v;
  logic       ref_en;
  logic [2:0] ana_en;
  logic       hp_en;
  logic       link_en;
  logic       clk_en;
  logic       settling;

  cpc_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  cpc_regfile #(.ADDR_W(ADDR_W), .REG_IDX(REG_IDX)) u_reg (
    .clk   (clk),
    .rst_n (rst_i_n),
    .we    (bus_we),
    .addr  (bus_addr),
    .wdata (bus_wdata),
    .rdy   (rdy_v),
    .req   (req),
    .rdata (bus_rdata)
  );

  assign go_v     = {ref_en, ana_en};
  assign settling = |busy_v;

  for (genvar g = 0; g < NRDY; g++) begin : g_settle
    cpc_settle #(.LIMIT(SETTLE_TAB[g])) u_cnt (
      .clk   (clk),
      .rst_n (rst_i_n),
      .go    (go_v[g]),
      .ready (rdy_v[g]),
      .busy  (busy_v[g])
    );
  end

  cpc_interlock u_lock (
    .req          (req),
    .slave_mode   (slave_mode),
    .mst_link_off (mst_link_off),
    .mst_clk_off  (mst_clk_off),
    .ref_rdy      (rdy_v[SUB_REF]),
    .settling     (settling),
    .ref_en       (ref_en),
    .ana_en       (ana_en),
    .hp_en        (hp_en),
    .link_en      (link_en),
    .clk_en       (clk_en)
  );

  assign sub_en = {hp_en, clk_en, link_en, ref_en, ana_en};

  // R4
  ref_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_en[SUB_ADC] || sub_en[SUB_DAC] || sub_en[SUB_MIX] || sub_en[SUB_HP]) |-> bus_rdata[SUB_REF]);

  // R5
  ref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sub_en[SUB_REF] |-> (!sub_en[SUB_ADC] && !sub_en[SUB_DAC]));

  // R6
  clk_deps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sub_en[SUB_CLK] |-> (!sub_en[SUB_ADC] && !sub_en[SUB_DAC] && !sub_en[SUB_LINK]));

  // R7
  clk_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sub_en[SUB_CLK] |-> ((sub_en[SUB_REF:SUB_ADC] & ~bus_rdata[NRDY-1:0]) == '0));

  // R8
  slv_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slave_mode |-> (sub_en[SUB_LINK] == !mst_link_off));
endmodule

// File: tb/sim_codec_pwr_ctl.sv
module sim_codec_pwr_ctl;
  localparam int LIM [4] = '{5, 7, 4, 9};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        slave_mode = 1'b0;
  logic        mst_link_off = 1'b0;
  logic        mst_clk_off = 1'b0;
  logic [6:0]  sub_en;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  codec_pwr_ctl #(
    .ADDR_W(7), .REG_IDX(7'h26),
    .ADC_SETTLE(LIM[0]), .DAC_SETTLE(LIM[1]), .MIX_SETTLE(LIM[2]), .REF_SETTLE(LIM[3])
  ) u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .slave_mode(slave_mode),
    .mst_link_off(mst_link_off), .mst_clk_off(mst_clk_off), .sub_en(sub_en)
  );

  // Reference model built from the requirements
  logic [1:0]  m_sync;
  logic [6:0]  m_req;
  int          m_cnt [4];
  logic [3:0]  m_go;
  logic [3:0]  m_rdy;
  logic [6:0]  exp_en;
  logic [15:0] exp_rd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_sync <= 2'b00;
    else        m_sync <= {m_sync[0], 1'b1};
  end

  always_comb begin
    logic ref_on, ref_ok, busy, link_off, clk_req;
    ref_on = !(m_req[3] && m_req[0] && m_req[1]);
    ref_ok = ref_on && (m_cnt[3] == LIM[3]);
    m_go   = {ref_on, !m_req[2] && ref_ok, !m_req[1] && ref_ok, !m_req[0] && ref_ok};
    busy   = 1'b0;
    for (int k = 0; k < 4; k++) begin
      m_rdy[k] = m_go[k] && (m_cnt[k] == LIM[k]);
      busy     = busy || (m_go[k] && (m_cnt[k] != LIM[k]));
    end
    link_off = slave_mode ? mst_link_off : m_req[4];
    clk_req  = m_req[5] || (slave_mode && mst_clk_off);
    exp_en   = {!m_req[6] && ref_ok,
                !(clk_req && m_req[0] && m_req[1] && link_off && !busy),
                !link_off, m_go};
    exp_rd   = {1'b0, m_req, 4'b0000, m_rdy};
  end

  always @(posedge clk or negedge m_sync[1]) begin
    if (!m_sync[1]) begin
      m_req <= '0;
      for (int k = 0; k < 4; k++) m_cnt[k] <= 0;
    end else begin
      if (bus_we && bus_addr == 7'h26) m_req <= bus_wdata[14:8];
      for (int k = 0; k < 4; k++) begin
        if (!m_go[k])              m_cnt[k] <= 0;
        else if (m_cnt[k] != LIM[k]) m_cnt[k] <= m_cnt[k] + 1;
      end
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    chk("R4 analog and headphone enables", {12'h0, sub_en[6], sub_en[2:0]}, {12'h0, exp_en[6], exp_en[2:0]});
    chk("R5 reference enable", {15'h0, sub_en[3]}, {15'h0, exp_en[3]});
    chk("R8 link enable", {15'h0, sub_en[4]}, {15'h0, exp_en[4]});
    chk("R6 clock enable", {15'h0, sub_en[5]}, {15'h0, exp_en[5]});
    chk("R3 readback", bus_rdata, exp_rd);
  endtask

  task automatic wr(input logic [6:0] a, input logic [15:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    step();
    bus_we = 1'b0;
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [6:0] pat;
    logic [31:0] r;
    void'($urandom(32'hC0DEC5));
    repeat (3) step();
    // R1 reset state
    chk("R1 reset enables", {9'h0, sub_en}, 16'h0038);
    chk("R1 reset readback", bus_rdata, 16'h0000);
    rst_n = 1'b1;
    step();
    chk("R1 held after release", {9'h0, sub_en}, 16'h0038);
    repeat (25) step();
    chk("R3 all ready", bus_rdata, 16'h000F);
    chk("R3 all enabled", {9'h0, sub_en}, 16'h007F);
    wr(7'h25, 16'h7F00);
    chk("R2 other address ignored", bus_rdata, 16'h000F);
    wr(7'h26, 16'hFFFF);
    chk("R2 status bits not writable", bus_rdata, 16'h7F00);
    chk("R10 standby enables", {9'h0, sub_en}, 16'h0000);
    wr(7'h26, 16'h3300);
    chk("R7 clock held while reference settles", {9'h0, sub_en}, 16'h0028);
    repeat (20) step();
    chk("R6 clock stops after settling", {9'h0, sub_en}, 16'h004C);
    chk("R3 ref and mixer ready", bus_rdata, 16'h330C);
    slave_mode = 1'b1; mst_link_off = 1'b1; mst_clk_off = 1'b0;
    wr(7'h26, 16'h2300);
    chk("R8 slave link from master", {15'h0, sub_en[4]}, 16'h0000);
    chk("R9 slave own clock request", {15'h0, sub_en[5]}, 16'h0000);
    mst_link_off = 1'b0;
    step();
    chk("R8 master link up", {9'h0, sub_en}, 16'h007C);
    mst_link_off = 1'b1; mst_clk_off = 1'b1;
    wr(7'h26, 16'h0300);
    chk("R9 master clock request", {9'h0, sub_en}, 16'h004C);
    slave_mode = 1'b0; mst_link_off = 1'b0; mst_clk_off = 1'b0;
    wr(7'h26, 16'h4000);
    chk("R11 headphone alone off", {9'h0, sub_en}, 16'h003F);

    for (int i = 0; i < 3000; i++) begin
      r = $urandom;
      if (r[1:0] == 2'b00) begin
        case (r[7:5])
          3'd0: pat = 7'h7F;
          3'd1: pat = 7'h00;
          3'd2: pat = 7'h33;
          3'd3: pat = 7'h0B;
          3'd4: pat = 7'h30;
          default: pat = 7'($urandom);
        endcase
        bus_we    = 1'b1;
        bus_addr  = (r[4:3] != 2'b00) ? 7'h26 : 7'($urandom);
        bus_wdata = 16'($urandom);
        bus_wdata[14:8] = pat;
      end else begin
        bus_we = 1'b0;
      end
      if (r[13:8] == 6'd0) slave_mode = ~slave_mode;
      if (r[16:14] == 3'd0) mst_link_off = r[17];
      if (r[20:18] == 3'd0) mst_clk_off = r[21];
      step();
    end
    bus_we = 1'b0;
    step();
    finished = 1'b1;
    summary();
    $finish;
  end
endmodule